// File: doc/BRIEF.md
# Parallel Very-High-Radix Montgomery Multiplier

This block computes a Montgomery product by consuming the multiplier operand X one V-bit digit at a time. In each iteration the low V bits of the running sum act as the reduction digit directly. A modified modulus Mt, supplied by the caller, removes the quotient multiply that a conventional reduction would need. The modified modulus is defined as Mt = (M'·M + 1) / 2^V, with M odd and M' = −M⁻¹ mod 2^V. The reduction product q·Mt and the digit product x_i·Y are added in the same step as the shifted running sum.

X is padded with one extra zero digit. With F = ceil(N/V) digits, the loop therefore runs F+1 times. Each step divides the running value by 2^V modulo M, so the result satisfies Z ≡ X·Y·2^(−V·F) (mod M). The result is not reduced below M. It always stays below 2^V·(Mt+Y), which is less than 2^(N+V+1). Computing Mt and any final subtraction are left to the surrounding logic.

A controller with three states sequences the work:
- IDLE waits. On the transition IDLE→ITER, taken when start is high, the operands are captured and Z is cleared.
- ITER performs one iteration per cycle. It stays in ITER until the last of the F+1 iterations, then takes ITER→DONE.
- DONE raises done for one cycle and always takes DONE→IDLE.

Top module: `mvr_montmul`

## Requirements
- R1: After reset, done is 0 and z_out is 0.
- R2: A start sampled high in IDLE is accepted. done then rises exactly F+1 rising edges after the accepting edge, and is high for exactly one cycle.
- R3: Each iteration takes q = Z[V-1:0] and sets Z to (Z >> V) + q·Mt + x_i·Y. Z is cleared when start is accepted. As a result, with Mt = 1, X = 1 and Y = 1 the result is exactly 1.
- R4: X digits are consumed least significant first. X is extended by one zero digit, so exactly F+1 iterations run, with F = ceil(N/V) (F = 4 for N = 32, V = 8).
- R5: For odd M and the matching Mt, z_out·2^(V·F) ≡ X·Y (mod M).
- R6: The result never overflows its N+V+1 bits, and z_out < 2^V·(Mt+Y).
- R7: start while ITER or DONE is ignored. The result and its timing are those of the run already in progress.
- R8: z_out holds its value from done until the next accepted start, whatever the operand inputs do.
- R9: X = 0 or Y = 0 gives z_out = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication (accepted in IDLE only) |
| x_in | input | N | Multiplier operand X, digits taken LSB first |
| y_in | input | N | Multiplicand operand Y |
| mmod_in | input | N | Modified modulus Mt |
| z_out | output | N+V+1 | Montgomery product, not reduced below M |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
The bench sends moduli near 2^32, near 2^31 and small, together with all-ones operands. It checks the congruence and the bound. A wrong digit order or a missing padding iteration breaks the congruence. A dropped carry breaks the bound.

A start injected mid-run must leave both the result and the cycle count unchanged. A controller that restarts would instead finish late with the wrong value.

The Mt = 1 case pins the exact step arithmetic. Zero operands must give zero. After done, changing the operand inputs must not disturb z_out, which catches a design that keeps iterating or re-captures its inputs.

// File: rtl/mvr_pkg.sv
package mvr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_DONE = 2'd2
    } mvr_state_e;
endpackage

// File: rtl/mvr_ctrl.sv
module mvr_ctrl
    import mvr_pkg::*;
#(
    parameter int ITERS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic done
);
    localparam int CW = $clog2(ITERS + 1);

    mvr_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == CW'(ITERS - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_ITER;
            ST_ITER: if (last)  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_ITER: step = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(step && last));

    assert_iter_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last) |=> (step && (cnt_q == $past(cnt_q) + 1'b1)));

    assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last) |=> !load);
endmodule

// File: rtl/mvr_digit_feed.sv
module mvr_digit_feed #(
    parameter int N = 32,
    parameter int V = 8,
    parameter int F = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         last,
    input  logic [N-1:0] x_in,
    output logic [V-1:0] digit
);
    localparam int XW = F * V;

    logic [XW-1:0] xr_q;

    // Digits leave LSB first; zeros fill the top, giving the padding digit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    xr_q <= '0;
        else if (load) xr_q <= XW'(x_in);
        else if (step) xr_q <= xr_q >> V;
    end

    assign digit = xr_q[V-1:0];

    assert_pad_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |-> (digit == '0));
endmodule

// File: rtl/mvr_accum_step.sv
module mvr_accum_step #(
    parameter int N = 32,
    parameter int V = 8
) (
    input  logic [N+V:0]   z_cur,
    input  logic [N-1:0]   y_op,
    input  logic [N-1:0]   mt_op,
    input  logic [V-1:0]   digit,
    output logic [N+V:0]   z_next,
    output logic           ovf
);
    localparam int ZW = N + V + 1;

    logic [V-1:0]   q;
    logic [N+V-1:0] p_red;
    logic [N+V-1:0] p_dig;
    logic [N:0]     z_sh;
    logic [ZW:0]    acc;

    // Reduction digit is simply the low V bits of the running sum
    assign q     = z_cur[V-1:0];
    assign z_sh  = z_cur[ZW-1:V];
    assign p_red = {{N{1'b0}}, q} * {{V{1'b0}}, mt_op};
    assign p_dig = {{N{1'b0}}, digit} * {{V{1'b0}}, y_op};
    assign acc   = {{(V+1){1'b0}}, z_sh} + {2'b00, p_red} + {2'b00, p_dig};

    assign z_next = acc[ZW-1:0];
    assign ovf    = acc[ZW];
endmodule

// File: rtl/mvr_montmul.sv
module mvr_montmul #(
    parameter int N = 32,
    parameter int V = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] x_in,
    input  logic [N-1:0] y_in,
    input  logic [N-1:0] mmod_in,
    output logic [N+V:0] z_out,
    output logic         done
);
    localparam int F     = (N + V - 1) / V;
    localparam int ITERS = F + 1;
    localparam int ZW    = N + V + 1;

    logic          load, step, last;
    logic [V-1:0]  digit;
    logic [N-1:0]  y_q, mt_q;
    logic [ZW-1:0] z_q, z_nx;
    logic          ovf;

    mvr_ctrl #(.ITERS(ITERS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .done  (done)
    );

    mvr_digit_feed #(.N(N), .V(V), .F(F)) u_feed (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .last  (last),
        .x_in  (x_in),
        .digit (digit)
    );

    mvr_accum_step #(.N(N), .V(V)) u_step (
        .z_cur  (z_q),
        .y_op   (y_q),
        .mt_op  (mt_q),
        .digit  (digit),
        .z_next (z_nx),
        .ovf    (ovf)
    );

    // Operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q  <= '0;
            mt_q <= '0;
        end else if (load) begin
            y_q  <= y_in;
            mt_q <= mmod_in;
        end
    end

    // Running sum
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    z_q <= '0;
        else if (load) z_q <= '0;
        else if (step) z_q <= z_nx;
    end

    assign z_out = z_q;

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !ovf);

    assert_load_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (z_q == '0));

    assert_hold_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(z_out));
endmodule

// File: tb/mvr_montmul_tb.sv
`timescale 1ns/1ps
module mvr_montmul_tb;
    localparam int N     = 32;
    localparam int V     = 8;
    localparam int F     = (N + V - 1) / V;
    localparam int ITERS = F + 1;
    localparam int ZW    = N + V + 1;
    localparam int NV    = 6;

    localparam logic [31:0] TM [NV] = '{32'hFFFF_FFFB, 32'h8000_0001, 32'hC0FF_EE11,
                                        32'h0000_FFF1, 32'h1234_5679, 32'hFFFF_FFFF};
    localparam logic [31:0] TX [NV] = '{32'h1234_5678, 32'hFFFF_FFFF, 32'hDEAD_BEEF,
                                        32'h0000_0001, 32'h0F0F_0F0F, 32'h7FFF_FFFF};
    localparam logic [31:0] TY [NV] = '{32'h9ABC_DEF0, 32'hFFFF_FFFF, 32'h00C0_FFEE,
                                        32'h0000_0003, 32'hF0F0_F0F0, 32'h8000_0000};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  x_in = '0, y_in = '0, mmod_in = '0;
    logic [ZW-1:0] z_out;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mvr_montmul #(.N(N), .V(V)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
        .mmod_in(mmod_in), .z_out(z_out), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mtilde(input logic [31:0] m);
        logic [39:0] p;
        int t;
        t = 0;
        for (int k = 0; k < 256; k++)
            if ((((m * k) & 32'hFF)) == 32'hFF) t = k;
        p = 40'(t) * 40'(m) + 40'd1;
        return p[39:8];
    endfunction

    // Runs one multiplication; optional extra start pulse while busy
    task automatic run(input logic [31:0] x, input logic [31:0] y, input logic [31:0] mt,
                       input bit poke, output logic [ZW-1:0] z, output int lat);
        @(negedge clk);
        x_in = x; y_in = y; mmod_in = mt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 2) begin
                start = 1'b1; x_in = ~x; y_in = ~y;
            end else if (poke && lat == 3) begin
                start = 1'b0;
            end
        end
        z = z_out;
        @(negedge clk);
        check(!done, "R2 done pulse width", 128'(done), 128'd0);
    endtask

    initial begin
        logic [ZW-1:0] z, z_ref;
        logic [31:0]   mt;
        logic [127:0]  lhs, rhs, bnd;
        int            lat, lat_ref;

        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 reset done", 128'(done), 128'd0);
        check(z_out == '0, "R1 reset z", 128'(z_out), 128'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            mt = mtilde(TM[i]);
            run(TX[i], TY[i], mt, 1'b0, z, lat);
            check(lat == ITERS, "R2 R4 latency", 128'(lat), 128'(ITERS));
            lhs = (128'(z) << (V * F)) % 128'(TM[i]);
            rhs = (128'(TX[i]) * 128'(TY[i])) % 128'(TM[i]);
            check(lhs == rhs, "R5 congruence", lhs, rhs);
            bnd = (128'(mt) + 128'(TY[i])) << V;
            check(128'(z) < bnd, "R6 bound", 128'(z), bnd);
        end

        // R3 exact step arithmetic with Mt = 1 (M = 255)
        run(32'd1, 32'd1, 32'd1, 1'b0, z, lat);
        check(z == ZW'(1), "R3 exact X=1 Y=1", 128'(z), 128'd1);
        run(32'h0300_0000, 32'd5, 32'd1, 1'b0, z, lat);
        check(z == ZW'(15), "R3 R4 top digit", 128'(z), 128'd15);

        // R9 zero operands
        run(32'd0, 32'hFFFF_FFFF, mtilde(32'hFFFF_FFFB), 1'b0, z, lat);
        check(z == '0, "R9 X zero", 128'(z), 128'd0);
        run(32'hFFFF_FFFF, 32'd0, mtilde(32'hFFFF_FFFB), 1'b0, z, lat);
        check(z == '0, "R9 Y zero", 128'(z), 128'd0);

        // R7 start while busy is ignored
        mt = mtilde(32'hC0FF_EE11);
        run(32'hDEAD_BEEF, 32'h00C0_FFEE, mt, 1'b0, z_ref, lat_ref);
        run(32'hDEAD_BEEF, 32'h00C0_FFEE, mt, 1'b1, z, lat);
        check(z == z_ref, "R7 busy start result", 128'(z), 128'(z_ref));
        check(lat == lat_ref, "R7 busy start timing", 128'(lat), 128'(lat_ref));

        // R8 result held while inputs change without start
        x_in = 32'h5555_5555; y_in = 32'hAAAA_AAAA; mmod_in = 32'h1;
        repeat (4) @(negedge clk);
        check(z_out == z_ref, "R8 hold", 128'(z_out), 128'(z_ref));
        check(done == 1'b0, "R8 no spurious done", 128'(done), 128'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule